// File: doc/BRIEF.md
# Paged Address Translation Buffer

The block is a fully associative translation buffer for a 32-bit virtual address space. Software loads entries by index. Each entry maps a pair of adjacent pages, one even and one odd. An entry holds a virtual page number, a page mask, an address-space identifier, a global bit, and two physical halves. Each half carries a frame number, a cache attribute, a dirty bit and a valid bit.

Each lookup takes these inputs: a virtual address, the requester's address-space identifier, an access kind (fetch, load or store), an access size and the processor status word. One clock later the block answers with either a physical address or one fault code. It also returns an uncacheable flag. The addresses of the faulting access are captured in registers that hold until the next fault.

The two directly mapped kernel segments bypass the table. Data alignment is checked before any translation. A probe port and an indexed read port let software find entries and read them back. A flush input invalidates the whole table in one cycle. A miss only raises a refill fault; walking the page table is left to software.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry reads back as zero and the probe reports not-found. `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and `rsp_pa`/`rsp_fault`/`rsp_uncached` describe that lookup.
- R2: When `wr_en` is high and `wr_idx` is below NUM_ENT, the entry at `wr_idx` is loaded at the clock edge. Writes at index NUM_ENT or above are ignored. The high word format is `{vpn[20:0], 3'b000, asid[7:0]}`, and bits 10:8 read back as zero. Each half word is `{pfn[21:0], c[2:0], d, v, g}`. The stored global bit is the AND of the two written g bits, and both halves read it back. Reads at index NUM_ENT or above return zero.
- R3: An entry matches a page number and identifier when both of these hold. First, at least one of its valid bits is set. Second, the page numbers agree at every bit where the entry's mask is 0, and either the entry is global or its identifier is equal. The probe uses `prb_hi[31:11]` and `prb_hi[7:0]`. It returns the lowest matching index, or `prb_miss`=1 with index 0. A lookup with several matches uses the lowest index.
- R4: The lookup page number is `va[31:11]`. When `small_pg` is 0, its two low bits are forced to zero before the compare.
- R5: For a mask with k low ones, the half is chosen by `va[10+k]`: 0 selects the even half and 1 selects the odd half. The physical address is `{pfn,10'b0}` with its low 10+k bits replaced by `va[9+k:0]`.
- R6: A mapped access with no matching entry faults. The code is 3 for a fetch and 4 for a load or store.
- R7: A match whose selected half has v=0 faults. The code is 5 for a fetch and 6 for a load or store.
- R8: A store to a valid half with d=0 faults with code 7.
- R9: `lk_type` encodes 0=fetch, 1=load, 2=store. A load or store with `va` not a multiple of `2**lk_size` bytes faults with code 1. This check takes precedence over every other check.
- R10: Addresses with `va[31:29]`=100 or 101 skip the table and give `pa = {3'b000, va[28:0]}`. A fetch whose `va[1:0]` is nonzero faults with code 2, except in the 101 segment.
- R11: An access with `va[31:29]`=100 faults with code 2 unless the processor is in kernel mode. Kernel mode means `status & 32'h1000_0006` is nonzero or `status[4:3]` is 00.
- R12: `rsp_uncached` is 1 exactly when bits 31 and 29 of the looked-up address are both set.
- R13: Any fault loads `bad_va` with the address. Codes 3 to 7 also load `flt_asid`, `flt_vpn2` (lookup page number >> 2) and `flt_vpn2x` (its two low bits). These registers are unchanged on a fault-free lookup, and the probe and readback ports do not alter them.
- R14: `flush` clears every valid bit at the clock edge and overrides a write in the same cycle. Afterwards the probe misses and a mapped lookup raises a refill fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Indexed entry write |
| wr_idx | input | IDX_W | Write index |
| wr_hi | input | 32 | Page number and identifier word |
| wr_lo0 | input | 28 | Even half word |
| wr_lo1 | input | 28 | Odd half word |
| wr_mask | input | 21 | Page mask, ones ignored in compare |
| flush | input | 1 | Invalidate all entries |
| rd_idx | input | IDX_W | Readback index |
| rd_hi | output | 32 | Readback high word |
| rd_lo0 | output | 28 | Readback even half |
| rd_lo1 | output | 28 | Readback odd half |
| rd_mask | output | 21 | Readback mask |
| prb_hi | input | 32 | Probe page number and identifier |
| prb_idx | output | IDX_W | Lowest matching index |
| prb_miss | output | 1 | No entry matches the probe |
| small_pg | input | 1 | 1 KB pages enabled |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_asid | input | 8 | Requester identifier |
| lk_type | input | 2 | 0 fetch, 1 load, 2 store |
| lk_size | input | 2 | log2 of access bytes |
| status | input | 32 | Processor status word |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 32 | Physical address, 0 on fault |
| rsp_uncached | output | 1 | Uncacheable address |
| rsp_fault | output | 3 | Fault code, 0 none |
| bad_va | output | 32 | Captured faulting address |
| flt_asid | output | 8 | Captured identifier |
| flt_vpn2 | output | 19 | Captured page number >> 2 |
| flt_vpn2x | output | 2 | Captured low page bits |

## Verification
The hardest case to reach is a store that lands in the odd half of a large-mask entry whose dirty bit is clear. The same address must lose to a lower-index duplicate or win over it. Random addresses almost never hit such an entry. The stimulus therefore builds each lookup address from an entry the reference model knows. It keeps the unmasked page bits and randomizes only the masked and offset bits. Identifiers and page numbers come from a small pool, so duplicate and global matches happen often. Directed steps first cover the small-page clearing, the segment privilege cases and a flush that coincides with a write.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int NUM_ENT = 8,
  parameter int IDX_W = $clog2(NUM_ENT) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_hi,
  input  logic [27:0]      wr_lo0,
  input  logic [27:0]      wr_lo1,
  input  logic [20:0]      wr_mask,
  input  logic             flush,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_hi,
  output logic [27:0]      rd_lo0,
  output logic [27:0]      rd_lo1,
  output logic [20:0]      rd_mask,
  input  logic [31:0]      prb_hi,
  output logic [IDX_W-1:0] prb_idx,
  output logic             prb_miss,
  input  logic             small_pg,
  input  logic             lk_valid,
  input  logic [31:0]      lk_va,
  input  logic [7:0]       lk_asid,
  input  logic [1:0]       lk_type,
  input  logic [1:0]       lk_size,
  input  logic [31:0]      status,
  output logic             rsp_valid,
  output logic [31:0]      rsp_pa,
  output logic             rsp_uncached,
  output logic [2:0]       rsp_fault,
  output logic [31:0]      bad_va,
  output logic [7:0]       flt_asid,
  output logic [18:0]      flt_vpn2,
  output logic [1:0]       flt_vpn2x
);
  localparam int SEL_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam logic [2:0] F_NONE = 3'd0, F_ALIGN = 3'd1, F_ADDR = 3'd2,
                         F_IREF = 3'd3, F_DREF = 3'd4, F_IINV = 3'd5,
                         F_DINV = 3'd6, F_MOD = 3'd7;
  localparam logic [1:0] T_FETCH = 2'd0, T_STORE = 2'd2;

  logic [20:0] e_vpn  [NUM_ENT];
  logic [20:0] e_mask [NUM_ENT];
  logic [7:0]  e_asid [NUM_ENT];
  logic        e_g    [NUM_ENT];
  logic [24:0] e_h0   [NUM_ENT];
  logic [24:0] e_h1   [NUM_ENT];
  logic        e_v0   [NUM_ENT];
  logic        e_v1   [NUM_ENT];

  logic unused_bits;
  assign unused_bits = ^{wr_hi[10:8], prb_hi[10:8]};

  logic wr_ok, rd_ok;
  assign wr_ok = int'(wr_idx) < NUM_ENT;
  assign rd_ok = int'(rd_idx) < NUM_ENT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        e_vpn[i] <= '0; e_mask[i] <= '0; e_asid[i] <= '0; e_g[i] <= 1'b0;
        e_h0[i] <= '0; e_h1[i] <= '0; e_v0[i] <= 1'b0; e_v1[i] <= 1'b0;
      end
    end else if (flush) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        e_v0[i] <= 1'b0;
        e_v1[i] <= 1'b0;
      end
    end else if (wr_en && wr_ok) begin
      e_vpn[wr_idx[SEL_W-1:0]]  <= wr_hi[31:11];
      e_asid[wr_idx[SEL_W-1:0]] <= wr_hi[7:0];
      e_mask[wr_idx[SEL_W-1:0]] <= wr_mask;
      e_g[wr_idx[SEL_W-1:0]]    <= wr_lo0[0] & wr_lo1[0];
      e_h0[wr_idx[SEL_W-1:0]]   <= {wr_lo0[27:6], wr_lo0[5:3]};
      e_h1[wr_idx[SEL_W-1:0]]   <= {wr_lo1[27:6], wr_lo1[5:3]};
      e_v0[wr_idx[SEL_W-1:0]]   <= wr_lo0[1];
      e_v1[wr_idx[SEL_W-1:0]]   <= wr_lo1[1];
    end
  end

  logic [SEL_W-1:0] rs;
  assign rs = rd_idx[SEL_W-1:0];
  assign rd_hi   = rd_ok ? {e_vpn[rs], 3'b000, e_asid[rs]} : '0;
  assign rd_mask = rd_ok ? e_mask[rs] : '0;
  assign rd_lo0  = rd_ok ? {e_h0[rs], d_bit(rs, 1'b0), e_v0[rs], e_g[rs]} : '0;
  assign rd_lo1  = rd_ok ? {e_h1[rs], d_bit(rs, 1'b1), e_v1[rs], e_g[rs]} : '0;

  logic e_d0 [NUM_ENT];
  logic e_d1 [NUM_ENT];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        e_d0[i] <= 1'b0;
        e_d1[i] <= 1'b0;
      end
    end else if (!flush && wr_en && wr_ok) begin
      e_d0[wr_idx[SEL_W-1:0]] <= wr_lo0[2];
      e_d1[wr_idx[SEL_W-1:0]] <= wr_lo1[2];
    end
  end

  function automatic logic d_bit(input logic [SEL_W-1:0] ix, input logic odd_h);
    return odd_h ? e_d1[ix] : e_d0[ix];
  endfunction

  logic [20:0] lk_vpn;
  assign lk_vpn = small_pg ? lk_va[31:11] : {lk_va[31:13], 2'b00};

  logic [NUM_ENT-1:0] lk_hit, pr_hit;
  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    logic live;
    assign live = e_v0[i] | e_v1[i];
    assign lk_hit[i] = live && (((lk_vpn ^ e_vpn[i]) & ~e_mask[i]) == '0) &&
                       (e_g[i] || e_asid[i] == lk_asid);
    assign pr_hit[i] = live && (((prb_hi[31:11] ^ e_vpn[i]) & ~e_mask[i]) == '0) &&
                       (e_g[i] || e_asid[i] == prb_hi[7:0]);
  end

  logic [SEL_W-1:0] lk_sel, pr_sel;
  logic             lk_any, pr_any;
  always_comb begin
    lk_sel = '0; lk_any = 1'b0;
    pr_sel = '0; pr_any = 1'b0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (lk_hit[i]) begin lk_sel = SEL_W'(i); lk_any = 1'b1; end
      if (pr_hit[i]) begin pr_sel = SEL_W'(i); pr_any = 1'b1; end
    end
  end
  assign prb_miss = !pr_any;
  assign prb_idx  = pr_any ? IDX_W'(pr_sel) : '0;

  logic [31:0] off_m;
  logic        odd, s_v, s_d;
  logic [21:0] s_pfn;
  logic [31:0] map_pa;
  assign off_m  = {1'b0, e_mask[lk_sel], 10'h3FF};
  assign odd    = |(lk_va & (off_m << 1) & ~off_m);
  assign s_pfn  = odd ? e_h1[lk_sel][24:3] : e_h0[lk_sel][24:3];
  assign s_v    = odd ? e_v1[lk_sel] : e_v0[lk_sel];
  assign s_d    = d_bit(lk_sel, odd);
  assign map_pa = ({s_pfn, 10'b0} & ~off_m) | (lk_va & off_m);

  logic kern, is_fetch, seg0, seg1, mis_d, mis_f;
  logic [3:0] sz_m;
  assign kern     = (|(status & 32'h1000_0006)) || (status[4:3] == 2'b00);
  assign is_fetch = lk_type == T_FETCH;
  assign seg0     = lk_va[31:29] == 3'b100;
  assign seg1     = lk_va[31:29] == 3'b101;
  assign sz_m     = 4'((4'd1 << lk_size) - 4'd1);
  assign mis_d    = |(lk_va[2:0] & sz_m[2:0]);
  assign mis_f    = |lk_va[1:0];

  logic [2:0]  n_fault;
  logic [31:0] n_pa;
  always_comb begin
    n_fault = F_NONE;
    n_pa    = '0;
    if (!is_fetch && mis_d)             n_fault = F_ALIGN;
    else if (seg0) begin
      if (!kern || (is_fetch && mis_f)) n_fault = F_ADDR;
      else                              n_pa = {3'b000, lk_va[28:0]};
    end
    else if (seg1)                      n_pa = {3'b000, lk_va[28:0]};
    else if (is_fetch && mis_f)         n_fault = F_ADDR;
    else if (!lk_any)                   n_fault = is_fetch ? F_IREF : F_DREF;
    else if (!s_v)                      n_fault = is_fetch ? F_IINV : F_DINV;
    else if (lk_type == T_STORE && !s_d) n_fault = F_MOD;
    else                                n_pa = map_pa;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_pa <= '0; rsp_uncached <= 1'b0; rsp_fault <= F_NONE;
      bad_va <= '0; flt_asid <= '0; flt_vpn2 <= '0; flt_vpn2x <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_pa       <= n_pa;
        rsp_fault    <= n_fault;
        rsp_uncached <= lk_va[31] & lk_va[29];
        if (n_fault != F_NONE) bad_va <= lk_va;
        if (n_fault >= F_IREF) begin
          flt_asid  <= lk_asid;
          flt_vpn2  <= lk_vpn[20:2];
          flt_vpn2x <= lk_vpn[1:0];
        end
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic [31:0] lk_va,
  input logic [1:0]  lk_type,
  input logic [1:0]  lk_size,
  input logic        flush,
  input logic        prb_miss,
  input logic        rsp_valid,
  input logic [31:0] rsp_pa,
  input logic        rsp_uncached,
  input logic [2:0]  rsp_fault,
  input logic [31:0] bad_va
);
  logic [2:0] low_m;
  always_comb begin
    case (lk_size)
      2'd0: low_m = 3'b000;
      2'd1: low_m = 3'b001;
      2'd2: low_m = 3'b011;
      default: low_m = 3'b111;
    endcase
  end

  // R1
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  // R9
  align_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_type != 2'd0 && (lk_va[2:0] & low_m) != 3'b000) |=> rsp_fault == 3'd1);
  // R10
  seg1_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_va[31:29] == 3'b101 && lk_type == 2'd0) |=>
      (rsp_fault == 3'd0 && rsp_pa == {3'b000, $past(lk_va[28:0])}));
  // R12
  uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_uncached == ($past(lk_va[31]) && $past(lk_va[29])));
  // R13
  badva_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rsp_fault == 3'd0 || bad_va == $past(lk_va)));
  // R14
  flush_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> prb_miss);
  // R6
  refill_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 (lk_valid && lk_type == 2'd0 && !lk_va[31] && lk_va[1:0] == 2'b00)
      |=> rsp_fault == 3'd3);
endmodule

bind tlb_xlate tlb_xlate_chk chk_i (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_type(lk_type),
  .lk_size(lk_size), .flush(flush), .prb_miss(prb_miss), .rsp_valid(rsp_valid),
  .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault), .bad_va(bad_va)
);

// File: tb/tlb_xlate_tb_top.sv
`timescale 1ns/100ps
module tlb_xlate_tb_top;
  localparam int NE = 8;
  localparam int IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, flush = 0, small_pg = 1, lk_valid = 0;
  logic [IW-1:0] wr_idx = 0, rd_idx = 0;
  logic [31:0] wr_hi = 0, prb_hi = 0, lk_va = 0, status = 0;
  logic [27:0] wr_lo0 = 0, wr_lo1 = 0;
  logic [20:0] wr_mask = 0;
  logic [7:0] lk_asid = 0;
  logic [1:0] lk_type = 0, lk_size = 0;
  logic [31:0] rd_hi, rsp_pa, bad_va;
  logic [27:0] rd_lo0, rd_lo1;
  logic [20:0] rd_mask;
  logic [IW-1:0] prb_idx;
  logic prb_miss, rsp_valid, rsp_uncached;
  logic [2:0] rsp_fault;
  logic [7:0] flt_asid;
  logic [18:0] flt_vpn2;
  logic [1:0] flt_vpn2x;

  always #2.5 clk = ~clk;

  tlb_xlate #(.NUM_ENT(NE), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi),
    .wr_lo0(wr_lo0), .wr_lo1(wr_lo1), .wr_mask(wr_mask), .flush(flush),
    .rd_idx(rd_idx), .rd_hi(rd_hi), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1), .rd_mask(rd_mask),
    .prb_hi(prb_hi), .prb_idx(prb_idx), .prb_miss(prb_miss), .small_pg(small_pg),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_type(lk_type),
    .lk_size(lk_size), .status(status), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault), .bad_va(bad_va),
    .flt_asid(flt_asid), .flt_vpn2(flt_vpn2), .flt_vpn2x(flt_vpn2x));

  int n_chk = 0, n_bad = 0;
  bit started = 0, done = 0;

  bit [31:0] m_hi [NE];
  bit [27:0] m_lo0 [NE], m_lo1 [NE];
  bit [20:0] m_mask [NE];
  bit        e_rv, e_unc, was_flush;
  bit [31:0] e_pa, e_bva;
  bit [2:0]  e_flt;
  bit [7:0]  e_asid;
  bit [18:0] e_vpn2;
  bit [1:0]  e_vpn2x;
  string     e_tag;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  function automatic int find(input bit [20:0] vpn, input bit [7:0] asid);
    for (int i = 0; i < NE; i++)
      if ((m_lo0[i][1] | m_lo1[i][1]) && (((vpn ^ m_hi[i][31:11]) & ~m_mask[i]) == 0) &&
          (m_lo0[i][0] || m_hi[i][7:0] == asid))
        return i;
    return -1;
  endfunction

  task automatic model_lookup();
    bit [20:0] vpn;
    bit kern;
    int h, k;
    bit [63:0] off;
    bit [27:0] half;
    vpn = lk_va[31:11];
    if (!small_pg) vpn[1:0] = 2'b00;
    kern = ((status & 32'h1000_0006) != 0) || (status[4:3] == 2'b00);
    e_pa = 0; e_flt = 0;
    e_unc = lk_va[31] && lk_va[29];
    if (lk_type != 0 && (lk_va % (32'd1 << lk_size)) != 0) begin e_flt = 1; e_tag = "R9"; end
    else if (lk_va[31:29] == 3'b100) begin
      if (!kern) begin e_flt = 2; e_tag = "R11"; end
      else if (lk_type == 0 && lk_va[1:0] != 0) begin e_flt = 2; e_tag = "R10"; end
      else begin e_pa = lk_va & 32'h1FFF_FFFF; e_tag = "R10"; end
    end
    else if (lk_va[31:29] == 3'b101) begin e_pa = lk_va & 32'h1FFF_FFFF; e_tag = "R10"; end
    else if (lk_type == 0 && lk_va[1:0] != 0) begin e_flt = 2; e_tag = "R10"; end
    else begin
      h = find(vpn, lk_asid);
      if (h < 0) begin e_flt = (lk_type == 0) ? 3 : 4; e_tag = "R6"; end
      else begin
        k = 0;
        for (int b = 0; b < 21; b++) if (m_mask[h][b]) k++;
        off = (64'd1 << (10 + k)) - 1;
        half = lk_va[10 + k] ? m_lo1[h] : m_lo0[h];
        if (!half[1]) begin e_flt = (lk_type == 0) ? 5 : 6; e_tag = "R7"; end
        else if (lk_type == 2 && !half[2]) begin e_flt = 7; e_tag = "R8"; end
        else begin
          e_pa = 32'((({42'b0, half[27:6]} << 10) & ~off) | ({32'b0, lk_va} & off));
          e_tag = small_pg ? "R5" : "R4";
        end
      end
    end
    if (e_flt != 0) e_bva = lk_va;
    if (e_flt >= 3) begin e_asid = lk_asid; e_vpn2 = vpn[20:2]; e_vpn2x = vpn[1:0]; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin m_hi[i] = 0; m_lo0[i] = 0; m_lo1[i] = 0; m_mask[i] = 0; end
      e_rv = 0; e_pa = 0; e_unc = 0; e_flt = 0; e_bva = 0; e_asid = 0; e_vpn2 = 0; e_vpn2x = 0;
      was_flush = 0; e_tag = "R1";
    end else begin
      e_rv = lk_valid;
      if (lk_valid) model_lookup();
      was_flush = flush;
      if (flush) begin
        for (int i = 0; i < NE; i++) begin m_lo0[i][1] = 0; m_lo1[i][1] = 0; end
      end else if (wr_en && wr_idx < NE) begin
        m_hi[wr_idx] = {wr_hi[31:11], 3'b000, wr_hi[7:0]};
        m_lo0[wr_idx] = {wr_lo0[27:1], wr_lo0[0] & wr_lo1[0]};
        m_lo1[wr_idx] = {wr_lo1[27:1], wr_lo0[0] & wr_lo1[0]};
        m_mask[wr_idx] = wr_mask;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && started && !done) begin
      int p;
      chk(rsp_valid, e_rv, "R1 rsp_valid");
      if (e_rv) begin
        chk(rsp_fault, e_flt, {e_tag, " fault"});
        chk(rsp_pa, e_pa, {e_tag, " pa"});
        chk(rsp_uncached, e_unc, "R12 uncached");
      end
      chk(bad_va, e_bva, "R13 bad_va");
      chk({flt_asid, flt_vpn2, flt_vpn2x}, {e_asid, e_vpn2, e_vpn2x}, "R13 fields");
      chk({rd_hi, rd_lo0, rd_lo1}, rd_idx < NE ? {m_hi[rd_idx], m_lo0[rd_idx], m_lo1[rd_idx]} : 88'd0, "R2 readback");
      chk(rd_mask, rd_idx < NE ? m_mask[rd_idx] : 21'd0, "R2 mask");
      p = find(prb_hi[31:11], prb_hi[7:0]);
      chk({prb_miss, prb_idx}, p < 0 ? {1'b1, 4'd0} : {1'b0, 4'(p)}, was_flush ? "R14 probe" : "R3 probe");
    end
  end

  task automatic step();
    @(posedge clk); #1;
    wr_en = 0; flush = 0; lk_valid = 0;
  endtask

  task automatic wr(input int idx, input bit [20:0] vpn, input bit [7:0] asid, input bit [20:0] msk,
                    input bit [27:0] l0, input bit [27:0] l1);
    wr_en = 1; wr_idx = IW'(idx); wr_hi = {vpn, 3'b111, asid}; wr_mask = msk; wr_lo0 = l0; wr_lo1 = l1;
    step();
  endtask

  task automatic lk(input bit [31:0] va, input bit [7:0] asid, input bit [1:0] ty, input bit [1:0] sz,
                    input bit [31:0] st);
    lk_valid = 1; lk_va = va; lk_asid = asid; lk_type = ty; lk_size = sz; status = st;
    step();
  endtask

  function automatic bit [27:0] half(input bit [21:0] pfn, input bit d, input bit v, input bit g);
    return {pfn, 3'b010, d, v, g};
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(prb_miss, 1'b1, "R1 reset probe");
    chk({rd_hi, rd_lo0, rd_lo1, rd_mask}, 0, "R1 reset entry");
    chk(rsp_valid, 1'b0, "R1 reset rsp");
    started = 1;
    @(posedge clk); #1;
    wr(0, 21'h40, 8'd5, 21'h0, half(22'h1234, 1, 1, 0), half(22'h0555, 0, 1, 0));
    wr(1, 21'h100, 8'd2, 21'h3, half(22'h2000, 0, 1, 1), half(22'h3000, 1, 0, 1));
    wr(2, 21'h40, 8'd7, 21'h0, half(22'h0777, 1, 1, 0), half(22'h0778, 1, 1, 0));
    wr(3, 21'h40, 8'd5, 21'h0, half(22'h0999, 1, 1, 0), half(22'h099A, 1, 1, 0));
    wr(8, 21'h40, 8'd5, 21'h0, half(22'h3FFF, 1, 1, 1), half(22'h3FFF, 1, 1, 1));
    wr(15, 21'h41, 8'd1, 21'h0, half(22'h3FFE, 1, 1, 1), half(22'h3FFE, 1, 1, 1));
    rd_idx = 0; prb_hi = {21'h40, 3'b0, 8'd5}; step();
    rd_idx = 8; prb_hi = {21'h40, 3'b0, 8'd7}; step();
    rd_idx = 1; prb_hi = {21'h103, 3'b0, 8'd9}; step();
    lk(32'h0002_0000, 5, 0, 2, 0);
    lk(32'h0002_0404, 5, 1, 2, 0);
    lk(32'h0002_0404, 5, 2, 2, 0);
    lk(32'h0002_0000, 5, 2, 0, 0);
    lk(32'h0002_0000, 6, 1, 0, 0);
    lk(32'h0002_0000, 6, 0, 0, 0);
    lk(32'h0002_0000, 7, 1, 0, 0);
    lk(32'h0008_0123, 9, 1, 0, 0);
    lk(32'h0008_1000, 9, 1, 0, 0);
    lk(32'h0008_1000, 9, 0, 0, 0);
    small_pg = 0; lk(32'h0002_0C00, 5, 1, 0, 0);
    small_pg = 1; lk(32'h0002_0C00, 5, 1, 0, 0);
    lk(32'h0002_0002, 5, 1, 2, 0);
    lk(32'h0000_0004, 5, 2, 3, 0);
    lk(32'h0002_0003, 5, 1, 0, 0);
    lk(32'h8000_1000, 0, 1, 2, 32'h0);
    lk(32'h8000_1000, 0, 1, 2, 32'h10);
    lk(32'h8000_1000, 0, 0, 2, 32'h12);
    lk(32'h8000_1000, 0, 1, 2, 32'h08);
    lk(32'h8000_1000, 0, 1, 2, 32'h1000_0010);
    lk(32'h8000_0002, 0, 0, 0, 32'h0);
    lk(32'hA000_0012, 0, 0, 0, 32'h10);
    lk(32'h0002_0002, 5, 0, 0, 0);
    lk(32'hE000_0000, 5, 1, 0, 0);
    wr_en = 1; wr_idx = 4; wr_hi = {21'h40, 3'b0, 8'd5}; wr_lo0 = half(1, 1, 1, 1); wr_lo1 = half(1, 1, 1, 1);
    flush = 1; prb_hi = {21'h40, 3'b0, 8'd5}; step();
    rd_idx = 4; lk(32'h0002_0000, 5, 0, 0, 0);
    step();
    for (int c = 0; c < 4000; c++) begin
      int j;
      bit [31:0] pm;
      bit [2:0] segs [4] = '{3'b000, 3'b001, 3'b110, 3'b111};
      if ($urandom % 4 == 0) begin
        wr_en = 1; wr_idx = IW'($urandom % 10);
        wr_hi = {segs[$urandom % 4], 11'b0, 5'($urandom % 8), 2'($urandom), 3'($urandom), 8'($urandom % 4)};
        wr_mask = 21'((32'd1 << ($urandom % 5)) - 1);
        wr_lo0 = 28'($urandom); wr_lo0[1] = ($urandom % 4) != 0;
        wr_lo1 = 28'($urandom); wr_lo1[1] = ($urandom % 4) != 0;
      end
      if ($urandom % 300 == 0) flush = 1;
      j = $urandom % NE;
      pm = {m_mask[j], 11'h7FF};
      lk_valid = ($urandom % 8) != 0;
      lk_va = ($urandom % 6 == 0) ? $urandom : (({m_hi[j][31:11], 11'b0} & ~pm) | ($urandom & pm));
      lk_asid = 8'($urandom % 4);
      lk_type = 2'($urandom % 3);
      lk_size = 2'($urandom);
      if ($urandom % 5 != 0) lk_va[2:0] = 3'b000;
      case ($urandom % 6)
        0: status = 32'h0; 1: status = 32'h10; 2: status = 32'h08;
        3: status = 32'h12; 4: status = 32'h18; default: status = 32'h1000_0010;
      endcase
      small_pg = ($urandom % 4) != 0;
      rd_idx = IW'($urandom);
      prb_hi = ($urandom % 2) ? m_hi[$urandom % NE] : {lk_va[31:11], 3'b0, lk_asid};
      @(posedge clk); #1;
      wr_en = 0; flush = 0; lk_valid = 0;
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule